// File: doc/BRIEF.md
# Multi-Input Wake-Up Controller

This unit watches sixteen external wake-up pins. Each pin passes through a two-flop synchronizer. A per-channel polarity bit then chooses whether a rising or a falling transition counts as a trigger. A trigger sets a sticky pending bit for that channel. The pending bit stays set until software removes it through a separate clear-only register. The CPU may also set pending bits directly, but a direct write to the pending register can never clear one. Because of this, a read-modify-write of the pending word cannot erase an event that hardware latched in the meantime.

Pending channels that are also enabled raise a single wake-up line toward power management. The same channels are steered to one of four interrupt request lines. Each channel has its own 2-bit routing field, packed eight to a word in two routing words. All registers sit on a word-wide bus with a 3-bit address:

| Address | Register |
|---|---|
| 0 | enable |
| 1 | edge polarity |
| 2 | pending |
| 3 | pending clear |
| 4 | routing word for channels 0–7 |
| 5 | routing word for channels 8–15 |

Top module: `wkup_ctrl`

## Requirements
- R1: After reset, every register reads 0 and all four interrupt lines and the wake-up line are low.
- R2: With polarity bit 0, a 0-to-1 change on a pin sets its pending bit (address 2, bit n for channel n). The bit becomes visible in the third rising clock edge after the change and not before.
- R3: With polarity bit 1, only a 1-to-0 change sets the pending bit. A transition in the direction the polarity bit does not select leaves the pending bit at 0.
- R4: Changing a polarity bit while the pin stays steady never sets the pending bit.
- R5: Writing the pending register (address 2) sets each bit written as 1. A bit written as 0 keeps its value.
- R6: Writing the clear register (address 3) clears each pending bit written as 1 and leaves the others unchanged. Reading address 3 returns 0.
- R7: If a trigger and a clear reach the same pending bit in the same cycle, the bit ends up set.
- R8: The routing field for channel k is bits [2k+1:2k] of address 4 for k<8, and bits [2(k-8)+1:2(k-8)] of address 5 otherwise. Field value j (00, 01, 10, 11) steers the channel to request j. Request j is high when some channel is pending, enabled and routed to j.
- R9: The wake-up line is high exactly when some channel is both pending and enabled (address 0). Pending bits latch whether or not the channel is enabled.
- R10: Addresses 0, 1, 4 and 5 read back the last value written. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when no read is selected |
| wake_pin | input | 16 | Asynchronous wake-up pins, bit n is channel n |
| irq_req | output | 4 | Interrupt request lines, bit j is request j |
| wake_out | output | 1 | Combined wake-up request to power management |

## Verification
The bench samples the pending word one cycle before and on the cycle the synchronizer latency allows. A design with a missing or extra flop would flag the event too early or too late. A design that compares polarity against the raw level rather than a real transition would latch a spurious event when only the polarity bit is toggled, or on a transition in the wrong direction. In the race test, a clear write lands on the same edge as a trigger on a bit that is already set; a design where the clear wins loses that event. The routing vectors put channels in both words and at the field edges (channels 7, 8, 15), so a field taken from the wrong bit positions misroutes the request.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int unsigned CH_N    = 16;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned REQ_N   = 4;
  localparam int unsigned SEL_W   = $clog2(REQ_N);
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned ROUTE_WORDS = (CH_N * SEL_W) / WORD_W;

  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd0;
  localparam logic [ADDR_W-1:0] A_EDGE   = 3'd1;
  localparam logic [ADDR_W-1:0] A_PEND   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ROUTE0 = 3'd4;

  // Next pending word: bus set, bus clear, then hardware triggers win.
  function automatic logic [CH_N-1:0] pend_next(
    input logic [CH_N-1:0] cur,
    input logic [CH_N-1:0] set_mask,
    input logic [CH_N-1:0] clr_mask,
    input logic [CH_N-1:0] trig
  );
    return ((cur | set_mask) & ~clr_mask) | trig;
  endfunction

  // Routing field of one channel out of the flattened routing store.
  function automatic logic [SEL_W-1:0] route_of(
    input logic [CH_N*SEL_W-1:0] route,
    input int unsigned ch
  );
    return route[ch*SEL_W +: SEL_W];
  endfunction
endpackage

// File: rtl/wkup_edge.sv
module wkup_edge
  import wkup_pkg::*;
#(
  parameter int unsigned NCH = CH_N
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin,
  input  logic [NCH-1:0] edge_sel,
  output logic [NCH-1:0] trig
);
  logic [NCH-1:0] meta_q;
  logic [NCH-1:0] sync_q;
  logic [NCH-1:0] prev_q;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q[i] <= 1'b0;
          sync_q[i] <= 1'b0;
          prev_q[i] <= 1'b0;
        end else begin
          meta_q[i] <= pin[i];
          sync_q[i] <= meta_q[i];
          prev_q[i] <= sync_q[i];
        end
      end
      // A real transition, qualified by polarity: 0 = rising, 1 = falling.
      assign trig[i] = (sync_q[i] ^ prev_q[i]) & (sync_q[i] ^ edge_sel[i]);
    end
  endgenerate
endmodule

// File: rtl/wkup_regs.sv
module wkup_regs
  import wkup_pkg::*;
#(
  parameter int unsigned NCH   = CH_N,
  parameter int unsigned DW    = WORD_W,
  parameter int unsigned SW    = SEL_W,
  parameter int unsigned AW    = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NCH-1:0]   trig,
  output logic [NCH-1:0]   en_q,
  output logic [NCH-1:0]   esel_q,
  output logic [NCH-1:0]   pend_q,
  output logic [NCH*SW-1:0] route_q
);
  localparam int unsigned RWORDS = (NCH * SW) / DW;

  logic wr_en, wr_edge, wr_pend, wr_clr, rd_go;
  logic [RWORDS-1:0] wr_route;
  logic [NCH-1:0] set_mask, clr_mask;

  assign rd_go   = bus_sel && !bus_we;
  assign wr_en   = bus_sel && bus_we && (bus_addr == A_ENABLE);
  assign wr_edge = bus_sel && bus_we && (bus_addr == A_EDGE);
  assign wr_pend = bus_sel && bus_we && (bus_addr == A_PEND);
  assign wr_clr  = bus_sel && bus_we && (bus_addr == A_CLEAR);
  assign set_mask = wr_pend ? bus_wdata[NCH-1:0] : '0;
  assign clr_mask = wr_clr  ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      esel_q <= '0;
      pend_q <= '0;
    end else begin
      if (wr_en)   en_q   <= bus_wdata[NCH-1:0];
      if (wr_edge) esel_q <= bus_wdata[NCH-1:0];
      pend_q <= pend_next(pend_q, set_mask, clr_mask, trig);
    end
  end

  generate
    for (genvar w = 0; w < RWORDS; w++) begin : g_route
      assign wr_route[w] = bus_sel && bus_we &&
                           (bus_addr == AW'(int'(A_ROUTE0) + w));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) route_q[w*DW +: DW] <= '0;
        else if (wr_route[w]) route_q[w*DW +: DW] <= bus_wdata;
      end
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (rd_go) begin
      if (bus_addr == A_ENABLE)    bus_rdata[NCH-1:0] = en_q;
      else if (bus_addr == A_EDGE) bus_rdata[NCH-1:0] = esel_q;
      else if (bus_addr == A_PEND) bus_rdata[NCH-1:0] = pend_q;
      else begin
        for (int w = 0; w < RWORDS; w++)
          if (bus_addr == AW'(int'(A_ROUTE0) + w)) bus_rdata = route_q[w*DW +: DW];
      end
    end
  end

  AST_TRIG_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != '0) |=> ((pend_q & $past(trig)) == $past(trig))); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && trig == '0) |=> ((pend_q & $past(bus_wdata[NCH-1:0])) == '0)); // R6
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_pend && trig == '0) |=> ((pend_q & ~$past(pend_q)) == '0)); // R5
endmodule

// File: rtl/wkup_route.sv
module wkup_route
  import wkup_pkg::*;
#(
  parameter int unsigned NCH  = CH_N,
  parameter int unsigned NREQ = REQ_N,
  parameter int unsigned SW   = SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pend,
  input  logic [NCH-1:0]    en,
  input  logic [NCH*SW-1:0] route,
  output logic [NREQ-1:0]   irq,
  output logic              wake
);
  logic [NCH-1:0] live;
  assign live = pend & en;

  generate
    for (genvar j = 0; j < NREQ; j++) begin : g_req
      logic [NCH-1:0] hit;
      always_comb begin
        for (int c = 0; c < NCH; c++)
          hit[c] = live[c] && (route_of(route, c) == SW'(j));
      end
      assign irq[j] = |hit;
    end
  endgenerate

  assign wake = |live;

  AST_WAKE_COVERS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> wake); // R9
  AST_WAKE_HAS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (irq != '0)); // R8
endmodule

// File: rtl/wkup_ctrl.sv
module wkup_ctrl
  import wkup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [CH_N-1:0]   wake_pin,
  output logic [REQ_N-1:0]  irq_req,
  output logic              wake_out
);
  logic [CH_N-1:0]       trig;
  logic [CH_N-1:0]       en_q, esel_q, pend_q;
  logic [CH_N*SEL_W-1:0] route_q;

  wkup_edge #(.NCH(CH_N)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(wake_pin), .edge_sel(esel_q), .trig(trig)
  );

  wkup_regs #(.NCH(CH_N), .DW(WORD_W), .SW(SEL_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig(trig), .en_q(en_q), .esel_q(esel_q), .pend_q(pend_q), .route_q(route_q)
  );

  wkup_route #(.NCH(CH_N), .NREQ(REQ_N), .SW(SEL_W)) u_route (
    .clk(clk), .rst_n(rst_n), .pend(pend_q), .en(en_q), .route(route_q),
    .irq(irq_req), .wake(wake_out)
  );

  AST_STEADY_POLARITY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(wake_pin) && $past($stable(wake_pin)) && $past($stable(wake_pin), 2)
     && !(bus_sel && bus_we)) |=> $stable(pend_q)); // R4
endmodule

// File: tb/wkup_ctrl_test.sv
module wkup_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] wake_pin = '0;
  logic [3:0]  irq_req;
  logic        wake_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wkup_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wake_pin(wake_pin), .irq_req(irq_req), .wake_out(wake_out)
  );

  // {enable, route word 0, route word 1, pending, expected irq, expected wake}
  localparam int NV = 6;
  localparam logic [68:0] VEC [NV] = '{
    {16'hFFFF, 16'h0000, 16'h0000, 16'h0001, 4'b0001, 1'b1},
    {16'hFFFF, 16'h0000, 16'hFFFF, 16'h0100, 4'b1000, 1'b1},
    {16'h00FF, 16'h0000, 16'hFFFF, 16'hFF00, 4'b0000, 1'b0},
    {16'hFFFF, 16'h0004, 16'h0020, 16'h0402, 4'b0110, 1'b1},
    {16'h8001, 16'hC000, 16'h4000, 16'h8081, 4'b0011, 1'b1},
    {16'hFFFF, 16'hAAAA, 16'h5555, 16'h0000, 4'b0000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, {16'h0, v}, {16'h0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 6; a++) expect_rd("R1", 3'(a), 16'h0000);
    chk("R1 irq", {28'h0, irq_req}, 32'h0);
    chk("R1 wake", {31'h0, wake_out}, 32'h0);

    // R8, R9: routing and wake vectors
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, VEC[i][68:53]);
      wr(3'd4, VEC[i][52:37]);
      wr(3'd5, VEC[i][36:21]);
      wr(3'd2, VEC[i][20:5]);
      chk("R8 irq", {28'h0, irq_req}, {28'h0, VEC[i][4:1]});
      chk("R9 wake", {31'h0, wake_out}, {31'h0, VEC[i][0]});
      wr(3'd3, 16'hFFFF);
      expect_rd("R6 clear all", 3'd2, 16'h0000);
    end
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'h0000);
    wr(3'd5, 16'h0000);

    // R5: set-only pending writes
    wr(3'd2, 16'h0010);
    wr(3'd2, 16'h0000);
    expect_rd("R5", 3'd2, 16'h0010);
    wr(3'd2, 16'h0200);
    expect_rd("R5", 3'd2, 16'h0210);
    // R6: selective clear, clear address reads 0
    wr(3'd3, 16'h0010);
    expect_rd("R6", 3'd2, 16'h0200);
    expect_rd("R6 read", 3'd3, 16'h0000);
    wr(3'd3, 16'h0200);

    // R10: readback and unused addresses
    wr(3'd1, 16'h00F0);
    expect_rd("R10 edge", 3'd1, 16'h00F0);
    wr(3'd4, 16'h1234);
    expect_rd("R10 route", 3'd4, 16'h1234);
    expect_rd("R10 a6", 3'd6, 16'h0000);
    expect_rd("R10 a7", 3'd7, 16'h0000);
    wr(3'd1, 16'h0000);
    wr(3'd4, 16'h0000);

    // R2: rising edge, latency; R9 pending latches while disabled
    wake_pin[3] = 1'b1;
    repeat (2) @(negedge clk);
    expect_rd("R2 early", 3'd2, 16'h0000);
    @(negedge clk);
    expect_rd("R2", 3'd2, 16'h0008);
    chk("R9 disabled wake", {31'h0, wake_out}, 32'h0);
    wr(3'd0, 16'h0008);
    chk("R9 enabled wake", {31'h0, wake_out}, 32'h1);
    chk("R8 default route", {28'h0, irq_req}, 32'h1);
    wr(3'd3, 16'hFFFF);
    wr(3'd0, 16'h0000);
    // R3: falling edge on a rising channel is ignored
    wake_pin[3] = 1'b0;
    repeat (3) @(negedge clk);
    expect_rd("R3 wrong dir", 3'd2, 16'h0000);

    // R3: falling polarity
    wr(3'd1, 16'h0020);
    wake_pin[5] = 1'b1;
    repeat (3) @(negedge clk);
    expect_rd("R3 rise ignored", 3'd2, 16'h0000);
    wake_pin[5] = 1'b0;
    repeat (3) @(negedge clk);
    expect_rd("R3 fall", 3'd2, 16'h0020);
    wr(3'd3, 16'hFFFF);
    wr(3'd1, 16'h0000);

    // R4: polarity toggling on a steady high pin
    wake_pin[6] = 1'b1;
    repeat (3) @(negedge clk);
    wr(3'd3, 16'hFFFF);
    wr(3'd1, 16'h0040);
    wr(3'd1, 16'h0000);
    repeat (3) @(negedge clk);
    expect_rd("R4", 3'd2, 16'h0000);

    // R7: trigger and clear on the same edge
    wr(3'd2, 16'h0100);
    wake_pin[8] = 1'b1;
    repeat (2) @(negedge clk);
    wr(3'd3, 16'h0100);
    expect_rd("R7", 3'd2, 16'h0100);
    wr(3'd3, 16'h0100);
    expect_rd("R7 later clear", 3'd2, 16'h0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule